// File: doc/BRIEF.md
# Run Length Violation Detector

This block sits behind a receiver's deserializer and watches the recovered bit stream for runs of identical bits that go on longer than a programmed limit. The stream arrives as one parallel word per recovered clock cycle. The word is 8, 10, 16 or 20 bits wide, and its least significant bit is the bit received first. A run of 0s and a run of 1s are treated alike. A run is followed across word boundaries, so a run that begins near the end of one word and goes on into later words is measured in bits (unit intervals), not in words.

When any bit position within the current word ends a run longer than the limit, the alarm output rises on the next clock edge. It then stays high for at least two clock cycles, so that slower logic can catch it. The largest limit that can take effect depends on the word width. A limit set above that ceiling is clamped to it. The internal run counter saturates, so a run of any length keeps the alarm asserted.

Top module: `run_length_monitor`

## Requirements
- R1: Runs of 0s and runs of 1s are both counted, and a run of either value that is longer than the limit raises the alarm.
- R2: The alarm is high after the clock edge that samples a word in which some valid bit ends a run strictly longer than the effective limit. A run exactly equal to the limit does not raise it.
- R3: Once raised, the alarm stays high for at least two cycles. A single offending word gives a pulse of exactly two cycles. Consecutive offending words keep the alarm high, and it falls two edges after the last offending word.
- R4: A run carries into the next word when the word's bit 0 equals the last valid bit of the previous word. Otherwise the run restarts at 1 with bit 0.
- R5: width_mode selects the word width: 0 gives 8 bits, 1 gives 10, 2 gives 16 and 3 gives 20. Only bits [width-1:0] of data_word are used, bit width-1 is the last bit of the word, and the upper bits are ignored.
- R6: The effective limit is run_limit clamped to a ceiling set by the mode: 128 in mode 0, 160 in mode 1, 512 in mode 2 and 640 in mode 3.
- R7: The limit counts single bits (unit intervals), not words.
- R8: The run counter saturates instead of wrapping, so a run of any length keeps the alarm high.
- R9: Synchronous reset clears the run count, the stored last bit and the hold timer, and drives the alarm low. The first bit after reset starts a new run of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock; one word per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_word | input | MAX_W (20) | Received word, bit 0 received first |
| width_mode | input | 2 | Word width select (0:8, 1:10, 2:16, 3:20) |
| run_limit | input | THR_W (10) | Largest run allowed, in bits |
| run_alarm | output | 1 | Registered violation flag, held for at least two cycles |

## Verification
A word presented before a rising edge affects run_alarm right after that same edge. The bench drives each word 1 ns after an edge and samples the alarm 1 ns after the next edge, which gives one cycle of latency for the rise. The pulse hold is then seen on the following one or two sampled cycles, and the fall comes on the second edge after the last offending word. A reference model in the bench tracks the run bit by bit together with the hold count. Each sample is compared with that model, so carries across words, clamped ceilings and saturated runs are all checked at the exact cycle when they take effect.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

  typedef enum logic [1:0] {
    WM_8  = 2'd0,
    WM_10 = 2'd1,
    WM_16 = 2'd2,
    WM_20 = 2'd3
  } width_mode_e;

  // ceiling in bits per word bit, for narrow and wide word modes
  localparam int unsigned UI_PER_BIT_NARROW = 16;
  localparam int unsigned UI_PER_BIT_WIDE   = 32;
  localparam int unsigned NARROW_MAX_BITS   = 10;

  function automatic int unsigned mode_bits(input logic [1:0] m);
    case (width_mode_e'(m))
      WM_8:    return 8;
      WM_10:   return 10;
      WM_16:   return 16;
      default: return 20;
    endcase
  endfunction

  function automatic int unsigned mode_ceiling(input logic [1:0] m);
    int unsigned b;
    b = mode_bits(m);
    return (b <= NARROW_MAX_BITS) ? b * UI_PER_BIT_NARROW : b * UI_PER_BIT_WIDE;
  endfunction

  localparam int unsigned WIDEST_BITS = 20;
  localparam int unsigned CEIL_MAX    = WIDEST_BITS * UI_PER_BIT_WIDE;

endpackage

// File: rtl/rlm_limit_clamp.sv
module rlm_limit_clamp
  import rlm_pkg::*;
#(
  parameter int THR_W = 10,
  parameter int CNT_W = 10
) (
  input  logic [1:0]       mode_i,
  input  logic [THR_W-1:0] raw_i,
  output logic [CNT_W-1:0] eff_o
);
  localparam int CMP_W = (THR_W > CNT_W) ? THR_W : CNT_W;

  logic [CNT_W-1:0] ceil_v;
  logic [CMP_W-1:0] raw_x;
  logic [CMP_W-1:0] ceil_x;

  always_comb begin
    ceil_v = CNT_W'(mode_ceiling(mode_i));
    raw_x  = CMP_W'(raw_i);
    ceil_x = CMP_W'(ceil_v);
    eff_o  = (raw_x > ceil_x) ? ceil_v : CNT_W'(raw_i);
  end

endmodule

// File: rtl/rlm_run_tracker.sv
module rlm_run_tracker
  import rlm_pkg::*;
#(
  parameter int MAX_W = 20,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAX_W-1:0] word_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  localparam int IDX_W = $clog2(MAX_W);
  localparam int NB_W  = $clog2(MAX_W + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == CNT_TOP) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0]            carry_q;
  logic                        last_q;
  logic [NB_W-1:0]             nbits;
  logic [IDX_W-1:0]            top_idx;
  logic [MAX_W-1:0]            valid;
  logic [MAX_W-1:0]            over;
  logic [MAX_W-1:0][CNT_W-1:0] run_vec;

  always_comb begin
    nbits   = NB_W'(mode_bits(mode_i));
    top_idx = IDX_W'(nbits - 1'b1);
  end

  // run length ending at each bit position, chained LSB to MSB
  for (genvar i = 0; i < MAX_W; i++) begin : g_pos
    logic [CNT_W-1:0] run;
    if (i == 0) begin : g_first
      assign run = (word_i[0] == last_q) ? bump(carry_q) : CNT_W'(1);
    end else begin : g_next
      assign run = (word_i[i] == word_i[i-1]) ? bump(g_pos[i-1].run) : CNT_W'(1);
    end
    assign run_vec[i] = run;
    assign valid[i]   = (NB_W'(i) < nbits);
    assign over[i]    = valid[i] && (run > limit_i);
  end

  assign hit_o = |over;

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= '0;
      last_q  <= 1'b0;
    end else begin
      carry_q <= run_vec[top_idx];
      last_q  <= word_i[top_idx];
    end
  end

  // word whose valid bits all continue the stored run
  logic uniform;
  always_comb begin
    uniform = 1'b1;
    for (int k = 0; k < MAX_W; k++) begin
      if (valid[k] && (word_i[k] != last_q)) uniform = 1'b0;
    end
  end

  // R4: a word that fully continues the run extends it by its width
  p_uniform_grow_r4: assert property (@(posedge clk) disable iff (rst)
    (uniform && (carry_q <= CNT_TOP - CNT_W'(MAX_W)))
    |=> (carry_q == $past(carry_q) + CNT_W'($past(nbits))));

  // R8: a saturated run stays saturated while it continues
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (uniform && (carry_q == CNT_TOP)) |=> (carry_q == CNT_TOP));

endmodule

// File: rtl/rlm_pulse_stretch.sv
module rlm_pulse_stretch #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  output logic flag_o
);
  localparam int HOLD_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;

  logic [HOLD_W-1:0] timer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
      flag_o  <= 1'b0;
    end else if (hit_i) begin
      timer_q <= HOLD_W'(HOLD_CYC - 1);
      flag_o  <= 1'b1;
    end else begin
      flag_o  <= (timer_q != '0);
      if (timer_q != '0) timer_q <= timer_q - 1'b1;
    end
  end

  // R2: an offending word raises the flag on the next edge
  p_hit_raises_r2: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> flag_o);

  // R3: a fresh flag is held for a second cycle
  p_min_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |=> flag_o);

  // R3: a low flag with no offending word stays low
  p_quiet_low_r3: assert property (@(posedge clk) disable iff (rst)
    (!hit_i && !flag_o) |=> !flag_o);

endmodule

// File: rtl/run_length_monitor.sv
module run_length_monitor
  import rlm_pkg::*;
#(
  parameter int MAX_W    = 20,
  parameter int THR_W    = 10,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAX_W-1:0] data_word,
  input  logic [1:0]       width_mode,
  input  logic [THR_W-1:0] run_limit,
  output logic             run_alarm
);
  localparam int CNT_W = $clog2(CEIL_MAX + 2);

  logic [CNT_W-1:0] eff_limit;
  logic             word_hit;

  rlm_limit_clamp #(
    .THR_W (THR_W),
    .CNT_W (CNT_W)
  ) u_clamp (
    .mode_i (width_mode),
    .raw_i  (run_limit),
    .eff_o  (eff_limit)
  );

  rlm_run_tracker #(
    .MAX_W (MAX_W),
    .CNT_W (CNT_W)
  ) u_track (
    .clk     (clk),
    .rst     (rst),
    .word_i  (data_word),
    .mode_i  (width_mode),
    .limit_i (eff_limit),
    .hit_o   (word_hit)
  );

  rlm_pulse_stretch #(
    .HOLD_CYC (HOLD_CYC)
  ) u_hold (
    .clk    (clk),
    .rst    (rst),
    .hit_i  (word_hit),
    .flag_o (run_alarm)
  );

endmodule

// File: tb/tb_run_length_monitor.sv
`timescale 1ns/1ps
module tb_run_length_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] data_word = '0;
  logic [1:0]  width_mode = 2'd0;
  logic [9:0]  run_limit = 10'd0;
  logic        run_alarm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_run = 0;
  bit m_last = 0;
  int m_hold = 0;
  bit m_exp = 0;

  always #2.5 clk = ~clk;

  run_length_monitor dut (
    .clk(clk), .rst(rst), .data_word(data_word),
    .width_mode(width_mode), .run_limit(run_limit), .run_alarm(run_alarm)
  );

  function automatic int bits_of(input logic [1:0] m);
    case (m) 2'd0: return 8; 2'd1: return 10; 2'd2: return 16; default: return 20; endcase
  endfunction

  function automatic int ceil_of(input logic [1:0] m);
    case (m) 2'd0: return 128; 2'd1: return 160; 2'd2: return 512; default: return 640; endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: run_alarm=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_word(input logic [19:0] w);
    int eff;
    bit hit;
    eff = (run_limit > ceil_of(width_mode)) ? ceil_of(width_mode) : int'(run_limit);
    hit = 0;
    for (int i = 0; i < bits_of(width_mode); i++) begin
      if (m_run > 0 && w[i] == m_last) m_run = (m_run >= 1023) ? 1023 : m_run + 1;
      else m_run = 1;
      m_last = w[i];
      if (m_run > eff) hit = 1;
    end
    if (hit) begin m_exp = 1; m_hold = 1; end
    else if (m_hold > 0) begin m_hold--; m_exp = 1; end
    else m_exp = 0;
  endtask

  task automatic push(input logic [19:0] w, input string tag);
    data_word = w;
    model_word(w);
    @(posedge clk); #1;
    check(run_alarm, m_exp, tag);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [9:0] lim);
    rst = 1'b1; data_word = '0; width_mode = m; run_limit = lim;
    @(posedge clk); #1;
    rst = 1'b0;
    m_run = 0; m_last = 0; m_hold = 0; m_exp = 0;
    check(run_alarm, 1'b0, "R9 after reset");
  endtask

  task automatic t_both_values;
    do_reset(2'd2, 10'd20);
    push(20'h0FFFF, "R1 ones 16");
    push(20'h0001F, "R1 ones 21");
    do_reset(2'd2, 10'd20);
    push(20'h00000, "R1 zeros 16");
    push(20'h0FFE0, "R1 zeros 21");
    check(run_alarm, 1'b1, "R1 zero run alarm");
    push(20'h0AAAA, "R1 alternating");
    push(20'h05555, "R1 alternating");
    check(run_alarm, 1'b0, "R1 alternating quiet");
  endtask

  task automatic t_threshold_edge;
    do_reset(2'd0, 10'd16);
    push(20'h000FF, "R2 run 8");
    push(20'h000FF, "R2 run equal 16");
    check(run_alarm, 1'b0, "R2 equal no alarm");
    push(20'h00001, "R2 run 17");
    check(run_alarm, 1'b1, "R2 exceed alarm");
  endtask

  task automatic t_stretch;
    do_reset(2'd1, 10'd9);
    push(20'h003FF, "R3 hit");
    push(20'h002AA, "R3 hold");
    check(run_alarm, 1'b1, "R3 second cycle");
    push(20'h00155, "R3 release");
    check(run_alarm, 1'b0, "R3 falls");
    push(20'h003FF, "R3 hit a");
    push(20'h003FF, "R3 hit b");
    push(20'h003FF, "R3 hit c");
    push(20'h00155, "R3 hold after last");
    push(20'h002AA, "R3 fall after last");
  endtask

  task automatic t_carry;
    do_reset(2'd2, 10'd10);
    push(20'h0FC00, "R4 tail 6 ones");
    push(20'h0FFDF, "R4 carry 6+5");
    check(run_alarm, 1'b1, "R4 carried run");
    do_reset(2'd2, 10'd10);
    push(20'h0FC00, "R4 tail 6 ones");
    push(20'h0FFDE, "R4 restart at bit0");
    check(run_alarm, 1'b0, "R4 restart no alarm");
  endtask

  task automatic t_width;
    do_reset(2'd0, 10'd10);
    push(20'hABC00, "R5 low byte zeros");
    push(20'h5A300, "R5 upper ignored 16");
    check(run_alarm, 1'b1, "R5 upper bits ignored");
    do_reset(2'd1, 10'd10);
    push(20'h00200, "R5 bit9 last");
    push(20'h003FF, "R5 run 11 from bit9");
    check(run_alarm, 1'b1, "R5 last bit is bit 9");
  endtask

  task automatic t_clamp;
    do_reset(2'd0, 10'd1023);
    for (int k = 0; k < 16; k++) push(20'h000FF, "R6 mode0 under 128");
    check(run_alarm, 1'b0, "R6 mode0 at ceiling");
    push(20'h000FF, "R6 mode0 over 128");
    check(run_alarm, 1'b1, "R6 mode0 clamp alarm");
    do_reset(2'd1, 10'd165);
    for (int k = 0; k < 16; k++) push(20'h003FF, "R6 mode1 under 160");
    push(20'h00001, "R6 mode1 run 161");
    check(run_alarm, 1'b1, "R6 mode1 clamp to 160");
    do_reset(2'd2, 10'd600);
    for (int k = 0; k < 32; k++) push(20'h0FFFF, "R6 mode2 under 512");
    push(20'h00001, "R6 mode2 run 513");
    check(run_alarm, 1'b1, "R6 mode2 clamp to 512");
    do_reset(2'd3, 10'd1000);
    for (int k = 0; k < 32; k++) push(20'hFFFFF, "R6 mode3 under 640");
    push(20'h00001, "R6 mode3 run 641");
    check(run_alarm, 1'b1, "R6 mode3 clamp to 640");
  endtask

  task automatic t_units;
    do_reset(2'd3, 10'd25);
    push(20'hFFFFF, "R7 run 20");
    check(run_alarm, 1'b0, "R7 under limit");
    push(20'h0003F, "R7 run 26");
    check(run_alarm, 1'b1, "R7 limit in bits");
  endtask

  task automatic t_saturate;
    do_reset(2'd3, 10'd640);
    for (int k = 0; k < 60; k++) push(20'hFFFFF, "R8 long run");
    check(run_alarm, 1'b1, "R8 alarm held past saturation");
  endtask

  task automatic t_reset_clear;
    do_reset(2'd0, 10'd120);
    for (int k = 0; k < 12; k++) push(20'h000FF, "R9 build run");
    do_reset(2'd0, 10'd120);
    for (int k = 0; k < 4; k++) push(20'h000FF, "R9 run cleared");
    check(run_alarm, 1'b0, "R9 count cleared");
    do_reset(2'd0, 10'd5);
    push(20'h000FF, "R9 hit before reset");
    do_reset(2'd0, 10'd5);
    push(20'h000AA, "R9 timer cleared");
    check(run_alarm, 1'b0, "R9 hold cleared");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_both_values();
    t_threshold_edge();
    t_stretch();
    t_carry();
    t_width();
    t_clamp();
    t_units();
    t_saturate();
    t_reset_clear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule